// File: doc/BRIEF.md
# Statistics Counter Bank

This block holds a set of traffic statistics counters for an Ethernet MAC, for example frames sent, frames received or collisions. Each counter has its own event input. A one-cycle pulse on that input adds one to the counter. Software reads the counters over a simple register bus. Every read returns its data one cycle after the request.

A control word on the same bus carries three test controls:
- A clear command sets every counter to zero.
- An increment command adds one to every counter in the same cycle.
- A write-enable flag lifts the write protection, so that software can load any counter with a chosen value.

A parameter selects whether counters stop at their maximum or wrap to zero. The default is to stop.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset, every counter reads 0, the control word reads 0 (write-enable off), and `rd_valid_o` and `rd_data_o` are 0.
- R2: A pulse on `evt_i[k]` adds one to counter k on the next clock edge. Counters whose event bit is low keep their value.
- R3: A counter at all-ones stays at all-ones when it receives an event or an increment command.
- R4: A bus write to address 0 with bit 5 set clears every counter on that edge. Events in the same cycle are dropped.
- R5: A bus write to address 0 with bit 6 set, and bit 5 clear, adds one to every counter on that edge.
- R6: When bits 5 and 6 are both set in one control write, every counter becomes 0.
- R7: A control write with bits 5 and 6 clear leaves every counter unchanged. A control read returns bit 7 equal to the stored write-enable flag and 0 in every other bit, bits 5 and 6 included. Bit 7 of each control write stores the flag.
- R8: While the write-enable flag is 0, a bus write to a counter address leaves that counter unchanged. An event on that counter in the same cycle is still counted.
- R9: While the write-enable flag is 1, a bus write to address k+1 loads counter k with the written value. A same-cycle event on that counter is dropped.
- R10: A read asserted in cycle t gives `rd_valid_o`=1 in cycle t+1. The data is the value from before any update made in cycle t.
- R10 (address map): address 0 is the control word, addresses 1 to 8 hold counters 0 to 7, and addresses 9 to 15 read 0.
- R11: When an increment command and an event on counter k arrive in the same cycle, counter k gains exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle event pulses, one per counter |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Word address: 0 control, 1..8 counters |
| bus_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after the read strobe |

## Verification
Saturation is the hardest situation to reach from the ports. Counting up to all-ones through events alone would take about four billion pulses. The stimulus therefore lifts write protection and loads a counter with all-ones minus one, with an event pulse on the same counter in that cycle, so the load-over-event priority is checked at the same time. Two more pulses then press the counter against its limit, and an increment command presses it again. Reads issued in the same cycle as an event confirm that read data reflects the value from before the update.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

   // Bit positions inside the control word (software decodes these)
   localparam int unsigned CTL_CLR_BIT = 5;
   localparam int unsigned CTL_INC_BIT = 6;
   localparam int unsigned CTL_WE_BIT  = 7;

   // Bank-wide command derived from a control write
   typedef enum logic [1:0] {
      BULK_NONE  = 2'd0,
      BULK_CLEAR = 2'd1,
      BULK_INCR  = 2'd2
   } bulk_cmd_e;

endpackage

// File: rtl/stat_bank_ctrl.sv
module stat_bank_ctrl
   import stat_bank_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctl_wr,
   input  logic      clr_bit,
   input  logic      inc_bit,
   input  logic      we_bit,
   output logic      we_q,
   output bulk_cmd_e bulk_cmd
);

   // Clear outranks increment
   always_comb begin
      bulk_cmd = BULK_NONE;
      if (ctl_wr) begin
         if (clr_bit)      bulk_cmd = BULK_CLEAR;
         else if (inc_bit) bulk_cmd = BULK_INCR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      we_q <= 1'b0;
      else if (ctl_wr) we_q <= we_bit;
   end

endmodule

// File: rtl/stat_bank_cnt.sv
module stat_bank_cnt
   import stat_bank_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bulk_cmd_e        bulk_cmd,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             evt,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_nxt;

   // Increment variant chosen by parameter
   generate
      if (SATURATE) begin : g_sat
         always_comb cnt_inc = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + CNT_W'(1);
      end else begin : g_wrap
         always_comb cnt_inc = cnt_q + CNT_W'(1);
      end
   endgenerate

   // Priority: clear > increment-all > software load > event
   always_comb begin
      unique case (bulk_cmd)
         BULK_CLEAR: cnt_nxt = '0;
         BULK_INCR:  cnt_nxt = cnt_inc;
         default: begin
            if (ld_en)    cnt_nxt = ld_val;
            else if (evt) cnt_nxt = cnt_inc;
            else          cnt_nxt = cnt_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/stat_bank_rdport.sv
module stat_bank_rdport
   import stat_bank_pkg::*;
#(
   parameter int unsigned NUM_CNT = 8,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rd_en,
   input  logic [ADDR_W-1:0]               rd_addr,
   input  logic                            we_q,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            rd_valid
);

   logic [DATA_W-1:0] sel_data;

   always_comb begin
      sel_data = '0;
      if (rd_addr == '0) begin
         sel_data[CTL_WE_BIT] = we_q;
      end
      for (int i = 0; i < NUM_CNT; i++) begin
         if (rd_addr == ADDR_W'(i + 1)) sel_data = DATA_W'(cnt_all[i]);
      end
   end

   // Registered read: captures values from before this edge's updates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= sel_data;
      end
   end

endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
   import stat_bank_pkg::*;
#(
   parameter int unsigned NUM_CNT  = 8,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned DATA_W   = 32,
   parameter bit          SATURATE = 1'b1,
   localparam int unsigned ADDR_W  = $clog2(NUM_CNT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CNT-1:0] evt_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o
);

   // Elaboration-time parameter checks
   generate
      if (NUM_CNT < 1) begin : g_err_num
         $error("stat_counter_bank: NUM_CNT must be at least 1");
      end
      if (DATA_W < 8) begin : g_err_dw
         $error("stat_counter_bank: DATA_W must hold the control bits");
      end
      if (CNT_W > DATA_W || CNT_W < 1) begin : g_err_cw
         $error("stat_counter_bank: CNT_W must be 1..DATA_W");
      end
   endgenerate

   logic                          ctl_wr;
   logic                          we_q;
   bulk_cmd_e                     bulk_cmd;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;

   assign ctl_wr = bus_wr_i && (bus_addr_i == '0);

   stat_bank_ctrl i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .clr_bit  (bus_wdata_i[CTL_CLR_BIT]),
      .inc_bit  (bus_wdata_i[CTL_INC_BIT]),
      .we_bit   (bus_wdata_i[CTL_WE_BIT]),
      .we_q     (we_q),
      .bulk_cmd (bulk_cmd)
   );

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
         logic ld_en;
         assign ld_en = bus_wr_i && we_q && (bus_addr_i == ADDR_W'(k + 1));

         stat_bank_cnt #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .bulk_cmd (bulk_cmd),
            .ld_en    (ld_en),
            .ld_val   (bus_wdata_i[CNT_W-1:0]),
            .evt      (evt_i[k]),
            .cnt_o    (cnt_all[k])
         );
      end
   endgenerate

   stat_bank_rdport #(
      .NUM_CNT (NUM_CNT),
      .CNT_W   (CNT_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) i_rdport (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd_i),
      .rd_addr  (bus_addr_i),
      .we_q     (we_q),
      .cnt_all  (cnt_all),
      .rd_data  (rd_data_o),
      .rd_valid (rd_valid_o)
   );

endmodule

// File: rtl/stat_bank_checker.sv
module stat_bank_checker #(
   parameter int unsigned NUM_CNT  = 8,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned DATA_W   = 32,
   parameter bit          SATURATE = 1'b1,
   parameter int unsigned ADDR_W   = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_CNT-1:0]            evt_i,
   input logic                          bus_wr_i,
   input logic                          bus_rd_i,
   input logic [ADDR_W-1:0]             bus_addr_i,
   input logic [DATA_W-1:0]             bus_wdata_i,
   input logic [DATA_W-1:0]             rd_data_o,
   input logic                          rd_valid_o,
   input logic                          we_q,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all
);

   logic ctl_wr;
   assign ctl_wr = bus_wr_i && (bus_addr_i == '0);

   p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_i |=> rd_valid_o);

   p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> !rd_valid_o);

   p_cmd_bits_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == '0) |=> (rd_data_o[6:5] == 2'b00));

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
         p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && bus_wdata_i[5]) |=> (cnt_all[k] == '0));

         p_event_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[k] && !bus_wr_i && cnt_all[k] != {CNT_W{1'b1}})
            |=> (cnt_all[k] == $past(cnt_all[k]) + CNT_W'(1)));

         p_protected_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && !we_q && bus_addr_i == ADDR_W'(k + 1) && !evt_i[k])
            |=> $stable(cnt_all[k]));

         p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && we_q && bus_addr_i == ADDR_W'(k + 1))
            |=> (cnt_all[k] == $past(bus_wdata_i[CNT_W-1:0])));

         if (SATURATE) begin : g_sat_chk
            p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (cnt_all[k] == {CNT_W{1'b1}} && !bus_wr_i)
               |=> (cnt_all[k] == {CNT_W{1'b1}}));
         end
      end
   endgenerate

endmodule

bind stat_counter_bank stat_bank_checker #(
   .NUM_CNT  (NUM_CNT),
   .CNT_W    (CNT_W),
   .DATA_W   (DATA_W),
   .SATURATE (SATURATE),
   .ADDR_W   (ADDR_W)
) i_stat_bank_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_i       (evt_i),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .rd_data_o   (rd_data_o),
   .rd_valid_o  (rd_valid_o),
   .we_q        (we_q),
   .cnt_all     (cnt_all)
);

// File: tb/test_stat_counter_bank.sv
module test_stat_counter_bank;

   localparam int NC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rvalid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   // Reference state built from the requirements
   logic [31:0] mdl [NC];
   bit          mdl_we = 1'b0;

   always #2 clk = ~clk;

   stat_counter_bank i_stat_counter_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .rd_data_o   (rdata),
      .rd_valid_o  (rvalid)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] sat1(input logic [31:0] v);
      return (v == 32'hFFFF_FFFF) ? v : v + 32'd1;
   endfunction

   function automatic logic [31:0] mdl_read(input logic [3:0] a);
      if (a == 4'd0) return {24'd0, mdl_we, 7'd0};
      if (a <= 4'(NC)) return mdl[a - 4'd1];
      return 32'd0;
   endfunction

   task automatic mdl_update(input logic [7:0] ev, input bit w, input logic [3:0] a,
                             input logic [31:0] d);
      if (w && a == 4'd0) begin
         if (d[5]) begin
            for (int i = 0; i < NC; i++) mdl[i] = 32'd0;
         end else if (d[6]) begin
            for (int i = 0; i < NC; i++) mdl[i] = sat1(mdl[i]);
         end
         mdl_we = d[7];
      end else begin
         for (int i = 0; i < NC; i++) begin
            if (w && mdl_we && a == 4'(i + 1)) mdl[i] = d;
            else if (ev[i])                    mdl[i] = sat1(mdl[i]);
         end
      end
   endtask

   // Driver: applies one cycle of stimulus, queues any expected read
   task automatic step(input logic [7:0] ev, input bit w, input bit r,
                       input logic [3:0] a, input logic [31:0] d, input string tag);
      @(negedge clk);
      evt = ev; wr = w; rd = r; addr = a; wdata = d;
      if (r) begin
         exp_q.push_back(mdl_read(a));
         tag_q.push_back(tag);
      end
      mdl_update(ev, w, a, d);
   endtask

   task automatic rd_all(input string tag);
      for (int a = 0; a <= NC; a++) step(8'h00, 1'b0, 1'b1, 4'(a), 32'd0, tag);
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input string tag);
      step(8'h00, 1'b1, 1'b0, a, d, tag);
   endtask

   // Monitor: compares each returned read against the queue
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) begin
            chk("R10 unexpected rd_valid", 32'd1, 32'd0);
         end else begin
            chk(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NC; i++) mdl[i] = 32'd0;
      repeat (3) @(negedge clk);
      chk("R1 rd_valid in reset", {31'd0, rvalid}, 32'd0);
      chk("R1 rd_data in reset", rdata, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd_valid after reset", {31'd0, rvalid}, 32'd0);
      rd_all("R1 reset value");

      // R2: several event patterns
      step(8'h01, 1'b0, 1'b0, 4'd0, 32'd0, "");
      step(8'hA5, 1'b0, 1'b0, 4'd0, 32'd0, "");
      step(8'hFF, 1'b0, 1'b0, 4'd0, 32'd0, "");
      step(8'hFF, 1'b0, 1'b0, 4'd0, 32'd0, "");
      step(8'h5A, 1'b0, 1'b0, 4'd0, 32'd0, "");
      rd_all("R2 event count");

      // R7: zero command bits, other bits ignored
      wr_reg(4'd0, 32'h0000_0000, "R7");
      rd_all("R7 zero command no effect");

      // R8: protected write ignored
      wr_reg(4'd4, 32'h0000_1234, "R8");
      rd_all("R8 protected write");

      // R7: write-enable readback, command bits read 0
      wr_reg(4'd0, 32'hFFFF_FF9F, "R7");
      rd_all("R7 control readback");

      // R9: load wins over same-cycle event on counter 2
      step(8'h04, 1'b1, 1'b0, 4'd3, 32'hFFFF_FFFE, "R9");
      step(8'h00, 1'b0, 1'b1, 4'd3, 32'd0, "R9 load over event");

      // R3: saturation by events
      step(8'h04, 1'b0, 1'b0, 4'd0, 32'd0, "");
      step(8'h04, 1'b0, 1'b0, 4'd0, 32'd0, "");
      step(8'h04, 1'b0, 1'b1, 4'd3, 32'd0, "R3 saturate by event");
      step(8'h00, 1'b0, 1'b1, 4'd3, 32'd0, "R3 saturate hold");

      // R10: read with same-cycle event returns old value
      step(8'h01, 1'b0, 1'b1, 4'd1, 32'd0, "R10 read before update");
      step(8'h00, 1'b0, 1'b1, 4'd1, 32'd0, "R10 read after update");

      // R5 / R11: increment-all with event on counter 0, WE kept
      step(8'h01, 1'b1, 1'b0, 4'd0, 32'h0000_00C0, "R5");
      rd_all("R5 R11 increment all");

      // R6: clear and increment together
      wr_reg(4'd0, 32'h0000_00E0, "R6");
      rd_all("R6 clear wins");

      // R4: clear after activity, with events in the clear cycle
      step(8'h3C, 1'b0, 1'b0, 4'd0, 32'd0, "");
      step(8'h3C, 1'b0, 1'b0, 4'd0, 32'd0, "");
      step(8'hFF, 1'b1, 1'b0, 4'd0, 32'h0000_00A0, "R4");
      rd_all("R4 clear all");

      // R10: unused addresses read zero
      for (int a = NC + 1; a < 16; a++) step(8'h00, 1'b0, 1'b1, 4'(a), 32'd0, "R10 unmapped read");

      // R8: protection back on, event still counts
      wr_reg(4'd0, 32'h0000_0000, "R8");
      step(8'h10, 1'b1, 1'b0, 4'd5, 32'h0000_DEAD, "R8");
      rd_all("R8 protected write with event");

      step(8'h00, 1'b0, 1'b0, 4'd0, 32'd0, "");
      repeat (3) @(negedge clk);
      chk("R10 outstanding reads", 32'(exp_q.size()), 32'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule